// File: doc/BRIEF.md
# PRBS Pattern Checker with Lock Detection

This block receives a serial bit stream, one bit on each clock edge where `rx_valid` is high, that is expected to carry a pseudorandom binary pattern. It predicts every incoming bit with a local shift register and reports mismatches as bit errors. A mode input selects either a 7-stage or a 15-stage generator. The local register starts empty and is seeded from the incoming bits.

A lock detector confirms synchronization before any error is counted. While locked, the local register runs on its own feedback, so a corrupted received bit cannot spoil later predictions. A burst of mismatches drops lock and starts reseeding. While locked, two saturating counters accumulate compared bits and errors for bit-error-rate measurement. A synchronous clear zeroes both counters and leaves lock untouched.

Top module: `prbs_checker`

## Requirements
- R1: With `mode`=0 the expected stream obeys b[n] = b[n-7] XOR b[n-6] (polynomial x^7+x^6+1, period 127). A clean stream of this kind locks and produces no errors.
- R2: With `mode`=1 the expected stream obeys b[n] = b[n-15] XOR b[n-14] (polynomial x^15+x^14+1, period 32767). A clean stream of this kind locks and produces no errors.
- R3: During acquisition the first N valid bits (N=7 or 15) are shifted into the local register. Each later valid bit is compared with the prediction and also shifted in. `locked` rises on the clock edge that takes the 32nd consecutive match, which is the (N+32)th valid bit of a clean stream.
- R4: A comparison made while the active N bits of the local register are all zero never counts as a match. A stream of all zeros therefore never locks. While locked, an all-zero register drops lock.
- R5: Mismatches seen before lock do not change `err_count` and raise no `err_pulse`.
- R6: While locked, each valid bit that differs from the free-running prediction raises `err_pulse` for exactly one cycle and adds one to `err_count`, both on the edge that takes the bit. A single flipped bit costs exactly one error.
- R7: `bit_count` rises by one for each valid bit compared while locked. Cycles with `rx_valid` low change no state.
- R8: While locked, `locked` falls on the edge that takes the 8th mismatch among the last 64 compared bits. That bit is still counted. Acquisition then restarts with an empty fill.
- R9: `err_count` and `bit_count` saturate at their all-ones value.
- R10: `cnt_clear` high at an edge zeroes both counters, taking priority over an increment at that edge. It leaves `locked` unchanged.
- R11: When `mode` differs from its value at the previous edge, `locked` falls, the valid bit of that cycle is discarded, the local register is emptied and acquisition restarts with the new polynomial.
- R12: After reset `locked`, `err_pulse` and both counters are zero, and the stored mode is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 1 | Generator select: 0 = 7-stage, 1 = 15-stage |
| rx_valid | input | 1 | Qualifies `rx_bit` for this cycle |
| rx_bit | input | 1 | Received serial bit |
| cnt_clear | input | 1 | Synchronous clear of both counters |
| locked | output | 1 | Pattern synchronization flag |
| err_pulse | output | 1 | One-cycle pulse per mismatched bit while locked |
| err_count | output | ERR_W | Saturating error count |
| bit_count | output | BIT_W | Saturating compared-bit count |

## Verification
Every result is registered once. The lock flag, the error pulse and both counters therefore reflect a received bit, a clear or a mode change right after the rising edge that takes it. No pipeline lag accumulates beyond that single edge. The bench drives inputs at the falling edge and updates its behavioural model at the rising edge. It compares all outputs with the model at the next falling edge, so every comparison falls half a cycle after the edge that produced the result. The named lock-timing checks count exactly N+32 valid bits, and the discarded bit on a mode change comes on top of that count.

// File: rtl/prbs_chk_pkg.sv
package prbs_chk_pkg;

  typedef enum logic {
    PRBS7  = 1'b0,
    PRBS15 = 1'b1
  } prbs_mode_e;

  localparam int REG_W = 15;

  // predicted next bit: b[n] = b[n-N] ^ b[n-N+1]; st[0] is newest
  function automatic logic prbs_predict(prbs_mode_e m, logic [REG_W-1:0] st);
    case (m)
      PRBS7:   return st[6] ^ st[5];
      default: return st[14] ^ st[13];
    endcase
  endfunction

  function automatic logic prbs_all_zero(prbs_mode_e m, logic [REG_W-1:0] st);
    case (m)
      PRBS7:   return (st[6:0] == 7'd0);
      default: return (st == '0);
    endcase
  endfunction

  function automatic logic [3:0] prbs_len(prbs_mode_e m);
    return (m == PRBS7) ? 4'd7 : 4'd15;
  endfunction

endpackage

// File: rtl/prbs_chk_lfsr.sv
module prbs_chk_lfsr
  import prbs_chk_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       flush,
  input  logic       step,
  input  logic       free_run,
  input  logic       rx_bit,
  input  prbs_mode_e mode,
  output logic       pred,
  output logic       zero
);
  logic [REG_W-1:0] st;

  assign pred = prbs_predict(mode, st);
  assign zero = prbs_all_zero(mode, st);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     st <= '0;
    else if (flush) st <= '0;
    else if (step)  st <= {st[REG_W-2:0], free_run ? pred : rx_bit};
  end
endmodule

// File: rtl/prbs_chk_lock.sv
module prbs_chk_lock #(
  parameter int LOCK_RUN = 32,
  parameter int WIN      = 64,
  parameter int LOSS_THR = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       restart,
  input  logic       step,
  input  logic       rx_bit,
  input  logic       pred,
  input  logic       zero,
  input  logic [3:0] fill_len,
  output logic       locked,
  output logic       mismatch,
  output logic       lock_gain,
  output logic       lock_loss
);
  localparam int RUN_W = $clog2(LOCK_RUN);
  localparam int WC_W  = $clog2(WIN + 1);

  logic [3:0]       fill;
  logic [RUN_W-1:0] run;
  logic [WIN-1:0]   hist;
  logic [WC_W-1:0]  wcnt, wcnt_next;
  logic             ready, good;

  assign mismatch  = rx_bit ^ pred;
  assign ready     = (fill >= fill_len);
  assign good      = !mismatch && !zero;
  assign wcnt_next = wcnt + WC_W'(mismatch) - WC_W'(hist[WIN-1]);
  assign lock_gain = step && !locked && ready && good && (run == RUN_W'(LOCK_RUN - 1));
  assign lock_loss = step && locked && ((wcnt_next >= WC_W'(LOSS_THR)) || zero);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      locked <= 1'b0;
      fill   <= '0;
      run    <= '0;
      hist   <= '0;
      wcnt   <= '0;
    end else if (restart) begin
      locked <= 1'b0;
      fill   <= '0;
      run    <= '0;
      hist   <= '0;
      wcnt   <= '0;
    end else if (step) begin
      if (!locked) begin
        if (!ready)         fill <= fill + 4'd1;
        else if (lock_gain) begin
          locked <= 1'b1;
          run    <= '0;
          hist   <= '0;
          wcnt   <= '0;
        end else if (good)  run <= run + RUN_W'(1);
        else                run <= '0;
      end else begin
        hist <= {hist[WIN-2:0], mismatch};
        wcnt <= wcnt_next;
        if (lock_loss) begin
          locked <= 1'b0;
          fill   <= '0;
          run    <= '0;
        end
      end
    end
  end
endmodule

// File: rtl/prbs_chk_satcnt.sv
module prbs_chk_satcnt #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                q <= '0;
    else if (clr)              q <= '0;
    else if (inc && q != '1)   q <= q + W'(1);
  end
endmodule

// File: rtl/prbs_checker.sv
module prbs_checker
  import prbs_chk_pkg::*;
#(
  parameter int ERR_W    = 32,
  parameter int BIT_W    = 48,
  parameter int LOCK_RUN = 32,
  parameter int WIN      = 64,
  parameter int LOSS_THR = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode,
  input  logic             rx_valid,
  input  logic             rx_bit,
  input  logic             cnt_clear,
  output logic             locked,
  output logic             err_pulse,
  output logic [ERR_W-1:0] err_count,
  output logic [BIT_W-1:0] bit_count
);
  prbs_mode_e mode_q;
  logic mode_chg, step, pred, state_zero;
  logic mismatch, lock_gain, lock_loss, cmp_locked, err_hit;

  assign mode_chg   = (prbs_mode_e'(mode) != mode_q);
  assign step       = rx_valid && !mode_chg;
  assign cmp_locked = step && locked;
  assign err_hit    = cmp_locked && mismatch;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q    <= PRBS7;
      err_pulse <= 1'b0;
    end else begin
      mode_q    <= prbs_mode_e'(mode);
      err_pulse <= err_hit;
    end
  end

  prbs_chk_lfsr u_lfsr (
    .clk(clk), .rst_n(rst_n), .flush(mode_chg), .step(step),
    .free_run(locked), .rx_bit(rx_bit), .mode(mode_q),
    .pred(pred), .zero(state_zero)
  );

  prbs_chk_lock #(.LOCK_RUN(LOCK_RUN), .WIN(WIN), .LOSS_THR(LOSS_THR)) u_lock (
    .clk(clk), .rst_n(rst_n), .restart(mode_chg), .step(step),
    .rx_bit(rx_bit), .pred(pred), .zero(state_zero),
    .fill_len(prbs_len(mode_q)), .locked(locked), .mismatch(mismatch),
    .lock_gain(lock_gain), .lock_loss(lock_loss)
  );

  prbs_chk_satcnt #(.W(ERR_W)) u_err_cnt (
    .clk(clk), .rst_n(rst_n), .clr(cnt_clear), .inc(err_hit), .q(err_count)
  );

  prbs_chk_satcnt #(.W(BIT_W)) u_bit_cnt (
    .clk(clk), .rst_n(rst_n), .clr(cnt_clear), .inc(cmp_locked), .q(bit_count)
  );
endmodule

// File: rtl/prbs_checker_sva.sv
module prbs_checker_sva #(
  parameter int ERR_W = 32,
  parameter int BIT_W = 48
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rx_valid,
  input logic             cnt_clear,
  input logic             locked,
  input logic             err_pulse,
  input logic [ERR_W-1:0] err_count,
  input logic [BIT_W-1:0] bit_count,
  input logic             mode_chg,
  input logic             lock_gain,
  input logic             lock_loss,
  input logic             state_zero
);
  localparam logic [ERR_W-1:0] EMAX = '1;
  localparam logic [BIT_W-1:0] BMAX = '1;

  assert_pulse_needs_lock_R5: assert property (@(posedge clk) disable iff (!rst_n)
    err_pulse |-> ($past(locked) && $past(rx_valid)));

  assert_pulse_counts_one_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (err_pulse && !$past(cnt_clear) && $past(err_count) != EMAX)
      |-> err_count == $past(err_count) + ERR_W'(1));

  assert_bits_only_locked_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_count != $past(bit_count) && !$past(cnt_clear)) |-> ($past(locked) && $past(rx_valid)));

  assert_err_saturates_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(err_count) == EMAX && !$past(cnt_clear)) |-> err_count == EMAX);

  assert_bits_saturate_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(bit_count) == BMAX && !$past(cnt_clear)) |-> bit_count == BMAX);

  assert_clear_zeroes_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_clear |=> (err_count == '0 && bit_count == '0));

  assert_mode_unlocks_R11: assert property (@(posedge clk) disable iff (!rst_n)
    mode_chg |=> !locked);

  assert_no_zero_lock_R4: assert property (@(posedge clk) disable iff (!rst_n)
    lock_gain |-> !state_zero);

  assert_loss_drops_R8: assert property (@(posedge clk) disable iff (!rst_n)
    lock_loss |=> !locked);
endmodule

bind prbs_checker prbs_checker_sva #(.ERR_W(ERR_W), .BIT_W(BIT_W)) u_sva (
  .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .cnt_clear(cnt_clear),
  .locked(locked), .err_pulse(err_pulse), .err_count(err_count),
  .bit_count(bit_count), .mode_chg(mode_chg), .lock_gain(lock_gain),
  .lock_loss(lock_loss), .state_zero(state_zero)
);

// File: tb/prbs_checker_test.sv
`timescale 1ns/1ps
module prbs_checker_test;
  localparam int TB_ERR_W = 5;
  localparam int TB_BIT_W = 12;
  localparam longint EMAX = (64'd1 << TB_ERR_W) - 1;
  localparam longint BMAX = (64'd1 << TB_BIT_W) - 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic mode = 1'b0, rx_valid = 1'b0, rx_bit = 1'b0, cnt_clear = 1'b0;
  logic locked, err_pulse;
  logic [TB_ERR_W-1:0] err_count;
  logic [TB_BIT_W-1:0] bit_count;

  always #4 clk = ~clk;

  prbs_checker #(.ERR_W(TB_ERR_W), .BIT_W(TB_BIT_W)) uut (
    .clk(clk), .rst_n(rst_n), .mode(mode), .rx_valid(rx_valid), .rx_bit(rx_bit),
    .cnt_clear(cnt_clear), .locked(locked), .err_pulse(err_pulse),
    .err_count(err_count), .bit_count(bit_count)
  );

  int nchk = 0, nfail = 0;
  bit done = 1'b0;

  task automatic chk(input string req, input longint act, input longint exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // ---- behavioural reference model ----
  int refq[$];
  int missq[$];
  bit m_mode, m_locked, m_pulse;
  int m_fill, m_run;
  longint m_err, m_bits;

  function automatic void ref_flush();
    refq = {};
    for (int i = 0; i < 15; i++) refq.push_back(0);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_mode = 0; m_locked = 0; m_pulse = 0; m_fill = 0; m_run = 0;
      m_err = 0; m_bits = 0; missq = {}; ref_flush();
    end else begin
      m_pulse = 0;
      if (mode != m_mode) begin
        m_mode = mode; m_locked = 0; m_fill = 0; m_run = 0;
        missq = {}; ref_flush();
      end else if (rx_valid) begin
        int n, p, z, s;
        n = m_mode ? 15 : 7;
        p = refq[15-n] ^ refq[16-n];
        z = 1;
        for (int i = 15 - n; i < 15; i++) if (refq[i] != 0) z = 0;
        if (!m_locked) begin
          refq.push_back(int'(rx_bit)); void'(refq.pop_front());
          if (m_fill < n) m_fill++;
          else if (z == 0 && int'(rx_bit) == p) begin
            m_run++;
            if (m_run == 32) begin m_locked = 1; m_run = 0; missq = {}; end
          end else m_run = 0;
        end else begin
          refq.push_back(p); void'(refq.pop_front());
          if (m_bits < BMAX) m_bits++;
          missq.push_back(int'(rx_bit) != p);
          if (missq.size() > 64) void'(missq.pop_front());
          if (int'(rx_bit) != p) begin
            m_pulse = 1;
            if (m_err < EMAX) m_err++;
          end
          s = 0;
          foreach (missq[i]) s += missq[i];
          if (s >= 8 || z == 1) begin m_locked = 0; m_fill = 0; m_run = 0; end
        end
      end
      if (cnt_clear) begin m_err = 0; m_bits = 0; end
    end
  end

  // per-cycle comparison, half a cycle after the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R3 locked vs model", longint'(locked), longint'(m_locked));
      chk("R6 err_pulse vs model", longint'(err_pulse), longint'(m_pulse));
      chk("R6 err_count vs model", longint'(err_count), m_err);
      chk("R7 bit_count vs model", longint'(bit_count), m_bits);
    end
  end

  // ---- transmitter ----
  int txq[$];
  function automatic void tx_seed(int n);
    txq = {};
    for (int i = 0; i < n; i++) txq.push_back(i == 0 ? 1 : 0);
  endfunction
  function automatic int tx_next();
    int b;
    b = txq[0] ^ txq[1];
    void'(txq.pop_front());
    txq.push_back(b);
    return b;
  endfunction

  task automatic send(input bit flip);
    @(negedge clk);
    rx_valid = 1'b1;
    rx_bit   = 1'(tx_next()) ^ flip;
  endtask
  task automatic idle();
    @(negedge clk);
    rx_valid  = 1'b0;
    cnt_clear = 1'b0;
  endtask
  task automatic send_clean(input int n, input bit gaps);
    for (int i = 0; i < n; i++) begin
      send(1'b0);
      if (gaps && ($urandom % 4 == 0)) idle();
    end
  endtask

  initial begin
    int ec;
    fork
      begin
        repeat (100000) @(posedge clk);
        if (!done) begin
          nchk++; nfail++;
          $display("FAIL watchdog: actual timeout expected completion");
          done = 1'b1;
          $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
          $finish;
        end
      end
    join_none

    repeat (3) @(negedge clk);
    chk("R12 locked at reset", longint'(locked), 0);
    chk("R12 err_pulse at reset", longint'(err_pulse), 0);
    chk("R12 err_count at reset", longint'(err_count), 0);
    chk("R12 bit_count at reset", longint'(bit_count), 0);
    rst_n = 1'b1;

    // R1 / R3: 7-stage lock after 7 + 32 valid bits
    tx_seed(7);
    send_clean(38, 1'b0); idle();
    chk("R3 not locked after 38 bits", longint'(locked), 0);
    send_clean(1, 1'b0); idle();
    chk("R3 locked after 39 bits", longint'(locked), 1);
    send_clean(200, 1'b1); idle();
    chk("R1 clean 7-stage stream has no errors", longint'(err_count), 0);
    chk("R7 bits counted with gaps", longint'(bit_count), 200);

    // R6: one injected error
    ec = int'(err_count);
    send(1'b1); idle();
    chk("R6 pulse for flipped bit", longint'(err_pulse), 1);
    chk("R6 one error counted", longint'(err_count), ec + 1);
    send_clean(100, 1'b0); idle();
    chk("R6 no follow-on errors", longint'(err_count), ec + 1);

    // R10: clear together with a compared bit
    send(1'b0); cnt_clear = 1'b1; idle();
    chk("R10 err_count cleared", longint'(err_count), 0);
    chk("R10 bit_count cleared", longint'(bit_count), 0);
    chk("R10 lock kept", longint'(locked), 1);

    // R8: seven errors keep lock, the eighth drops it
    for (int i = 0; i < 7; i++) begin send(1'b1); send(1'b0); end
    idle();
    chk("R8 lock held at 7 errors", longint'(locked), 1);
    send(1'b1); idle();
    chk("R8 lock lost at 8th error", longint'(locked), 0);
    send_clean(100, 1'b0); idle();
    chk("R8 relock after loss", longint'(locked), 1);

    // R11 / R2: mode change and 15-stage lock
    @(negedge clk); mode = 1'b1; rx_valid = 1'b1; rx_bit = 1'b1;
    tx_seed(15);
    idle();
    chk("R11 mode change drops lock", longint'(locked), 0);
    send_clean(46, 1'b0); idle();
    chk("R2 not locked after 46 bits", longint'(locked), 0);
    send_clean(1, 1'b0); idle();
    chk("R2 locked after 47 bits", longint'(locked), 1);
    ec = int'(err_count);
    send_clean(300, 1'b1); idle();
    chk("R2 clean 15-stage stream has no errors", longint'(err_count), ec);

    // R4: all-zero stream never locks
    for (int i = 0; i < 300; i++) begin
      @(negedge clk); rx_valid = 1'b1; rx_bit = 1'b0;
    end
    idle();
    chk("R4 zero stream unlocked", longint'(locked), 0);

    // R5: errors during acquisition are not counted
    ec = int'(err_count);
    send_clean(20, 1'b0); send(1'b1); send_clean(5, 1'b0); send(1'b1); idle();
    chk("R5 no counting before lock", longint'(err_count), ec);
    send_clean(100, 1'b0); idle();
    chk("R5 lock after acquisition errors", longint'(locked), 1);

    // R9: saturation of both counters
    cnt_clear = 1'b1; idle();
    for (int i = 0; i < 400; i++) send(i % 10 == 9);
    idle();
    chk("R9 error count saturates", longint'(err_count), EMAX);
    chk("R9 lock kept under sparse errors", longint'(locked), 1);
    send_clean(4200, 1'b0); idle();
    chk("R9 bit count saturates", longint'(bit_count), BMAX);

    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule